// File: doc/BRIEF.md
# Leading/Trailing Zero Count Unit

This unit scans a 64-bit datapath operand and reports how many zero bits lie next to one of its ends before the first set bit. A direction select chooses whether the scan starts at the most significant end (leading zeros) or at the least significant end (trailing zeros). A size select limits the scan to the low 32-bit word, so that the upper half of the operand has no effect on the count.

The count is registered on the rising clock edge and returned as a 64-bit value, zero-extended. An operand field with no set bit yields the width of that field. Internally, per-byte zero flags feed a byte-level priority select. A trailing count reuses the leading-zero logic on a bit-reversed field.

Top module: `zcnt_top`

## Requirements
- R1: While `rst_n` is low at a rising edge, `count` becomes 0 after that edge.
- R2: `count` shows the result for the inputs that were present at the previous rising edge. This is exactly one cycle of latency.
- R3: With `from_lsb`=0 and `word_mode`=0, `count` is the number of zeros above the highest set bit of `operand[63:0]`.
- R4: With `from_lsb`=1 and `word_mode`=0, `count` is the number of zeros below the lowest set bit of `operand[63:0]`.
- R5: With `from_lsb`=0 and `word_mode`=1, `count` is the number of zeros above the highest set bit of `operand[31:0]`. Bits 63..32 have no effect.
- R6: With `from_lsb`=1 and `word_mode`=1, `count` is the number of zeros below the lowest set bit of `operand[31:0]`. Bits 63..32 have no effect.
- R7: If the scanned field holds no set bit, `count` is 64 in doubleword mode and 32 in word mode, in both directions. This holds even when upper bits are set in word mode.
- R8: Bits 63..7 of `count` are always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| operand | input | 64 | Value to scan |
| from_lsb | input | 1 | 0: count leading zeros, 1: count trailing zeros |
| word_mode | input | 1 | 1: scan only bits 31..0 |
| count | output | 64 | Registered zero count, zero-extended |

## Verification
The only result is `count`, and it is due one rising edge after the inputs are applied. The bench changes the inputs just after a falling edge. It then waits for the next falling edge, which follows exactly one rising edge, and compares `count` there against a reference computed by walking the bits. In this way each check sees the capture of exactly one input set. Reset is checked the same way: the bench holds `rst_n` low across one rising edge and samples at the following falling edge.

// File: rtl/zcnt_pkg.sv
// Package: shared sizing for the zero count unit.
// Assumes the data width is a power of two and a multiple of the lane width.
package zcnt_pkg;
    localparam int ZC_DATA_W = 64;
    localparam int ZC_LANE_W = 8;
    localparam int ZC_CNT_W  = $clog2(ZC_DATA_W) + 1;
endpackage

// File: rtl/zcnt_lane.sv
// Module: zcnt_lane
// Examines one lane of bits. It reports whether the whole lane is zero and,
// if it is not, how many zeros precede the highest set bit of the lane.
// Assumes LANE_W is a power of two.
module zcnt_lane #(
    parameter int LANE_W = 8,
    localparam int CW    = $clog2(LANE_W)
) (
    input  logic [LANE_W-1:0] bits,
    output logic              all_zero,
    output logic [CW-1:0]     lead_cnt
);
    // Priority scan from LSB upward; the last set bit seen is the highest.
    always_comb begin
        lead_cnt = '0;
        for (int i = 0; i < LANE_W; i++) begin
            if (bits[i]) lead_cnt = CW'(LANE_W - 1 - i);
        end
    end

    // Lane-wide zero flag.
    assign all_zero = ~|bits;
endmodule

// File: rtl/zcnt_prio.sv
// Module: zcnt_prio
// Counts the leading zeros of a DATA_W-bit vector. Per-lane zero flags feed a
// lane-level priority select, which is then combined with that lane's local count.
// An all-zero vector gives DATA_W. The logic is purely combinational.
module zcnt_prio #(
    parameter int DATA_W  = zcnt_pkg::ZC_DATA_W,
    parameter int LANE_W  = zcnt_pkg::ZC_LANE_W,
    localparam int NL     = DATA_W / LANE_W,
    localparam int SW     = (NL > 1) ? $clog2(NL) : 1,
    localparam int LCW    = $clog2(LANE_W),
    localparam int OW     = $clog2(DATA_W) + 1
) (
    input  logic [DATA_W-1:0] vec,
    output logic [OW-1:0]     lead_cnt
);
    logic [NL-1:0]  lane_zero;
    logic [LCW-1:0] lane_cnt [NL];
    logic [SW-1:0]  sel;

    for (genvar g = 0; g < NL; g++) begin : g_lane
        zcnt_lane #(.LANE_W(LANE_W)) lane_i (
            .bits     (vec[g*LANE_W +: LANE_W]),
            .all_zero (lane_zero[g]),
            .lead_cnt (lane_cnt[g])
        );
    end

    // Lane priority: pick the most significant lane that holds a set bit.
    always_comb begin
        sel = '0;
        for (int k = 0; k < NL; k++) begin
            if (!lane_zero[k]) sel = SW'(k);
        end
    end

    // Combine the whole empty lanes above the selected one with its local count.
    always_comb begin
        if (&lane_zero) begin
            lead_cnt = OW'(DATA_W);
        end else begin
            lead_cnt = OW'((NL - 1 - int'(sel)) * LANE_W) + OW'(lane_cnt[sel]);
        end
    end
endmodule

// File: rtl/zcnt_top.sv
// Module: zcnt_top
// Leading/trailing zero count over a 64-bit operand or its low 32-bit word,
// registered once. A trailing count bit-reverses the field and reuses the
// leading-zero encoder. Word mode places the low word at the top of the
// encoder input, with a sentinel 1 right below it, so the count caps at HALF.
// Reset is synchronous and active low.
module zcnt_top #(
    parameter int DATA_W = zcnt_pkg::ZC_DATA_W,
    parameter int LANE_W = zcnt_pkg::ZC_LANE_W,
    localparam int HALF  = DATA_W / 2,
    localparam int OW    = $clog2(DATA_W) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] operand,
    input  logic              from_lsb,
    input  logic              word_mode,
    output logic [DATA_W-1:0] count
);
    logic [DATA_W-1:0] rev_full;
    logic [HALF-1:0]   rev_word;
    logic [DATA_W-1:0] enc_in;
    logic [OW-1:0]     enc_cnt;
    logic [OW-1:0]     cnt_q;

    for (genvar b = 0; b < DATA_W; b++) begin : g_rev_full
        assign rev_full[b] = operand[DATA_W-1-b];
    end
    for (genvar b = 0; b < HALF; b++) begin : g_rev_word
        assign rev_word[b] = operand[HALF-1-b];
    end

    // Field select: direction and size choose the encoder input.
    always_comb begin
        unique case ({word_mode, from_lsb})
            2'b00: enc_in = operand;
            2'b01: enc_in = rev_full;
            2'b10: enc_in = {operand[HALF-1:0], 1'b1, {(HALF-1){1'b0}}};
            default: enc_in = {rev_word, 1'b1, {(HALF-1){1'b0}}};
        endcase
    end

    zcnt_prio #(.DATA_W(DATA_W), .LANE_W(LANE_W)) prio_i (
        .vec      (enc_in),
        .lead_cnt (enc_cnt)
    );

    // Output register: capture the count, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= enc_cnt;
    end

    assign count = DATA_W'(cnt_q);

    // R1
    reset_clear_chk: assert property (@(posedge clk) !rst_n |=> count == '0);
    // R3
    lead_top_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!from_lsb && !word_mode && operand[DATA_W-1]) |=> count == '0);
    // R4
    trail_bottom_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (from_lsb && operand[0]) |=> count == '0);
    // R7
    empty_dword_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!word_mode && operand == '0) |=> count == DATA_W'(DATA_W));
    // R7
    empty_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (word_mode && operand[HALF-1:0] == '0) |=> count == DATA_W'(HALF));
    // R5
    word_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_mode |=> count <= DATA_W'(HALF));
endmodule

// File: tb/zcnt_top_tb_top.sv
// Bench for zcnt_top. It walks a vector table, sweeps a lone boundary bit
// through every position against a bit-walking reference, and runs directed
// reset checks.
module zcnt_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [63:0] operand;
    logic        from_lsb;
    logic        word_mode;
    logic [63:0] count;
    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    zcnt_top dut_i (
        .clk(clk), .rst_n(rst_n), .operand(operand),
        .from_lsb(from_lsb), .word_mode(word_mode), .count(count)
    );

    typedef struct packed {
        logic [63:0] op;
        logic        lsb;
        logic        word;
        logic [6:0]  exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{64'h8000_0000_0000_0000, 1'b0, 1'b0, 7'd0,  8'd3},
        '{64'h0000_0000_0000_0001, 1'b0, 1'b0, 7'd63, 8'd3},
        '{64'h0000_0000_0000_0001, 1'b1, 1'b0, 7'd0,  8'd4},
        '{64'h8000_0000_0000_0000, 1'b1, 1'b0, 7'd63, 8'd4},
        '{64'hFFFF_FFFF_0000_8000, 1'b0, 1'b1, 7'd16, 8'd5},
        '{64'h0000_0001_8000_0000, 1'b0, 1'b1, 7'd0,  8'd5},
        '{64'hFFFF_FFFF_0001_0000, 1'b1, 1'b1, 7'd16, 8'd6},
        '{64'h0000_0001_8000_0000, 1'b1, 1'b1, 7'd31, 8'd6},
        '{64'h0000_0000_0000_0000, 1'b0, 1'b0, 7'd64, 8'd7},
        '{64'h0000_0000_0000_0000, 1'b1, 1'b0, 7'd64, 8'd7},
        '{64'hFFFF_FFFF_0000_0000, 1'b0, 1'b1, 7'd32, 8'd7},
        '{64'h8000_0001_0000_0000, 1'b1, 1'b1, 7'd32, 8'd7}
    };

    function automatic int ref_count(logic [63:0] v, logic lsb, logic word);
        int w = word ? 32 : 64;
        int n = 0;
        for (int i = 0; i < w; i++) begin
            int idx = lsb ? i : (w - 1 - i);
            if (v[idx]) return n;
            n++;
        end
        return n;
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: operand=%h lsb=%0b word=%0b count=%0d expected=%0d",
                     req, operand, from_lsb, word_mode, act, exp);
        end
    endtask

    // Apply at a falling edge; the result is due after one rising edge (R2).
    task automatic apply(logic [63:0] v, logic lsb, logic word, string req);
        operand = v; from_lsb = lsb; word_mode = word;
        @(negedge clk);
        check(req, count, 64'(ref_count(v, lsb, word)));
        check("R8", {count[63:7], 7'd0}, 64'd0);
    endtask

    initial begin
        rst_n = 1'b0; operand = '1; from_lsb = 1'b0; word_mode = 1'b0;
        @(negedge clk); @(negedge clk);
        check("R1", count, 64'd0);
        rst_n = 1'b1;

        for (int k = 0; k < NV; k++) begin
            operand = VECS[k].op; from_lsb = VECS[k].lsb; word_mode = VECS[k].word;
            @(negedge clk);
            check($sformatf("R%0d", VECS[k].req), count, 64'(VECS[k].exp));
        end

        // R2: back-to-back changes; each result belongs to the previous edge only.
        apply(64'h0000_0000_0000_0100, 1'b0, 1'b0, "R2");
        apply(64'h0000_0000_0000_0100, 1'b1, 1'b0, "R2");

        // Sweeps: one boundary bit at every position, random bits on the far side.
        for (int p = 0; p < 64; p++) begin
            for (int t = 0; t < 3; t++) begin
                logic [63:0] r = {$urandom, $urandom};
                logic [63:0] lead_v  = (r & ((64'd1 << p) - 1)) | (64'd1 << p);
                logic [63:0] trail_v = (r & ~((64'd1 << p) - 1)) | (64'd1 << p);
                apply(lead_v,  1'b0, 1'b0, "R3");
                apply(trail_v, 1'b1, 1'b0, "R4");
                apply({r[63:32], lead_v[31:0] | (p >= 32 ? 32'd0 : 32'd0)}, 1'b0, 1'b1, "R5");
                apply({r[63:32], trail_v[31:0]}, 1'b1, 1'b1, "R6");
            end
        end

        // R5/R6: upper half toggled with a fixed low word gives the same count.
        apply(64'h0000_0000_0000_0010, 1'b0, 1'b1, "R5");
        apply(64'hFFFF_FFFF_0000_0010, 1'b0, 1'b1, "R5");
        apply(64'h5A5A_5A5A_0000_0010, 1'b1, 1'b1, "R6");
        // R7: upper half set, low word empty, both directions.
        apply(64'hFFFF_FFFF_0000_0000, 1'b0, 1'b1, "R7");
        apply(64'hFFFF_FFFF_0000_0000, 1'b1, 1'b1, "R7");

        // R1: reset mid-run clears a nonzero count.
        apply(64'd0, 1'b0, 1'b0, "R7");
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", count, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", count, 64'd64);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule